// File: doc/BRIEF.md
# FM Synthesizer Register Decoder and Key Control

This block sits at the write port of a six-channel, two-operator FM synthesizer. A host writes a byte to one of 64 register addresses. The block keeps three things: an eight-byte user-defined instrument, three bytes of state per channel (frequency low byte, key/frequency high byte, and instrument/volume byte), and one key flag per channel.

From that state it presents, to the phase and envelope stages, the fully decoded parameter set of all twelve operators. Operator 2c is the modulator of channel c and operator 2c+1 is its carrier. It also presents each channel's frequency, block, sustain and feedback settings.

Instrument number 0 picks the user-defined instrument, and numbers 1 to 15 pick presets from a constant ROM vector tied to an input. A write to a key byte is compared with the stored key flag. A rising key restarts both operators of that channel. A falling key sends only the carrier into release. Each of these events is a single-cycle pulse.

Top module: `fm_key_ctrl`

## Requirements
- R1: The write address is 6 bits wide. Addresses 0x00 to 0x07 store user-instrument bytes 0 to 7. Every channel whose instrument number is 0 decodes the new byte one cycle after the write.
- R2: An instrument number p from 1 to 15 makes the channel decode byte k from `preset_rom[((p-1)*8+k)*8 +: 8]`. Such a channel is not affected by writes to the user instrument.
- R3: A write to 0x10+c sets bits 7:0 of channel c's 9-bit frequency. At 0x20+c, the bits are assigned as follows: bit 0 is frequency bit 8, bits 3:1 are the block, and bit 5 is sustain. These appear on `ch_fnum[c*9+:9]`, `ch_block[c*3+:3]` and `ch_sustain[c]` one cycle after the write.
- R4: At 0x30+c, bits 7:4 are the instrument number. Bits 3:0 are the carrier volume v, and the carrier's total level becomes 4*v. The modulator's total level comes from instrument byte 2.
- R5: A write to 0x20+c with bit 4 set, while `ch_key[c]` is 0, pulses `key_restart[c]` for exactly one cycle, in the cycle after the write. A write with bit 4 set while `ch_key[c]` is already 1 gives no pulse. `ch_key[c]` takes the written bit 4 in the same cycle.
- R6: A write to 0x20+c with bit 4 clear, while `ch_key[c]` is 1, pulses `car_release[c]` for one cycle after the write. With the flag already 0, there is no pulse.
- R7: Each operator's parameters are given by `op_params[k*33 +: 33]`, with the fields listed from MSB to LSB: am, pm, eg, kr, mult[3:0], ksl[1:0], tl[5:0], wf, ar[3:0], dr[3:0], sl[3:0], rr[3:0].
  - The modulator takes am, pm, eg, kr and mult from byte 0, and the carrier takes them from byte 1 (bits 7, 6, 5, 4, 3:0).
  - The modulator takes ksl and tl from byte 2 (bits 7:6 and 5:0).
  - Byte 3 gives the carrier ksl (bits 7:6), the carrier wf (bit 4) and the modulator wf (bit 3).
  - Bytes 4 and 6 give the modulator's ar/dr and sl/rr as high/low nibbles. Bytes 5 and 7 give the same fields for the carrier.
- R8: The feedback code f is bits 2:0 of instrument byte 3. When f is nonzero, `ch_fb_en[c]` is 1 and `ch_fb_shift[c*3+:3]` is 7-f. When f is 0, both are 0.
- R9: Writes to undefined addresses change no output. The undefined addresses are 0x08 to 0x0F, and in each of the ranges 0x10, 0x20 and 0x30, offsets 6 to 15.
- R10: Synchronous active-low reset clears all stored state to zero. This state is the same as all 64 addresses holding 0: no key flags, no pulses, feedback disabled and all operator fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 8 | Register data |
| preset_rom | input | 960 | Constant preset instrument table, 15 x 8 bytes |
| ch_fnum | output | 54 | Per-channel 9-bit frequency number |
| ch_block | output | 18 | Per-channel 3-bit block |
| ch_sustain | output | 6 | Per-channel sustain bit |
| ch_key | output | 6 | Per-channel key flag |
| key_restart | output | 6 | One-cycle restart pulse for both operators of a channel |
| car_release | output | 6 | One-cycle release pulse for a channel's carrier |
| ch_fb_shift | output | 18 | Per-channel modulator feedback shift |
| ch_fb_en | output | 6 | Per-channel feedback enable |
| op_params | output | 396 | Decoded parameters of 12 operators, 33 bits each |

## Verification
A single key-byte write to a channel changes its frequency, block and sustain in the same cycle that it raises or lowers the key flag and emits a restart or release pulse. The bench provokes this with key writes that also carry new block and frequency bits, and with back-to-back key writes to different channels, so that one channel's pulse overlaps the next channel's write. It also writes user-instrument bytes in the cycle right after a restart. The behavioural model in the bench predicts every output for every cycle, and all outputs are compared each cycle, so a pulse that is lost, late or duplicated, or a register that is updated in the wrong cycle, is caught.

// File: rtl/fm_reg_pkg.sv
// Shared constants and types for the FM register decoder.
// Assumes 8-bit data and eight-byte instruments.
package fm_reg_pkg;
    localparam int BYTE_W      = 8;
    localparam int PATCH_BYTES = 8;
    localparam int PATCH_W     = PATCH_BYTES * BYTE_W;
    localparam int INST_W      = 4;
    localparam int N_PRESET    = (1 << INST_W) - 1;
    localparam int ADDR_W      = 6;

    // Decoded parameters of one operator, MSB first.
    typedef struct packed {
        logic       am;
        logic       pm;
        logic       eg;
        logic       kr;
        logic [3:0] mult;
        logic [1:0] ksl;
        logic [5:0] tl;
        logic       wf;
        logic [3:0] ar;
        logic [3:0] dr;
        logic [3:0] sl;
        logic [3:0] rr;
    } op_param_t;

    localparam int OP_W = $bits(op_param_t);

    typedef logic [PATCH_W-1:0] patch_t;
endpackage

// File: rtl/fm_custom_regs.sv
// Holds the eight user-instrument bytes written at addresses 0x00-0x07.
// Assumes the address is already limited to ADDR_W bits.
module fm_custom_regs
    import fm_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output patch_t            custom
);
    localparam int SEL_W = $clog2(PATCH_BYTES);

    logic [PATCH_BYTES-1:0][BYTE_W-1:0] bytes_q;
    logic                               hit;

    // Address falls in the user-instrument window.
    assign hit = wr_en && (wr_addr[ADDR_W-1:SEL_W] == '0);

    // Store the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bytes_q <= '0;
        else if (hit)
            bytes_q[wr_addr[SEL_W-1:0]] <= wr_data;
    end

    assign custom = bytes_q;
endmodule

// File: rtl/fm_chan_regs.sv
// Per-channel frequency, key and instrument/volume registers with key-edge
// detection. Assumes one write per cycle; pulses last exactly one cycle.
module fm_chan_regs
    import fm_reg_pkg::*;
#(
    parameter int N_CH = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    output logic [N_CH-1:0][8:0]          fnum,
    output logic [N_CH-1:0][2:0]          block,
    output logic [N_CH-1:0]               sustain,
    output logic [N_CH-1:0]               key,
    output logic [N_CH-1:0]               restart,
    output logic [N_CH-1:0]               release_car,
    output logic [N_CH-1:0][INST_W-1:0]   inst,
    output logic [N_CH-1:0][5:0]          car_tl
);
    localparam logic [1:0] GRP_LO  = 2'd1;
    localparam logic [1:0] GRP_HI  = 2'd2;
    localparam logic [1:0] GRP_INS = 2'd3;

    logic [1:0] grp;
    logic [3:0] idx;

    assign grp = wr_addr[5:4];
    assign idx = wr_addr[3:0];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic       hit_lo, hit_hi, hit_ins;
        logic [7:0] lo_q;
        logic [5:0] hi_q;
        logic [7:0] ins_q;
        logic       rs_q, rl_q;

        assign hit_lo  = wr_en && (grp == GRP_LO)  && (idx == 4'(c));
        assign hit_hi  = wr_en && (grp == GRP_HI)  && (idx == 4'(c));
        assign hit_ins = wr_en && (grp == GRP_INS) && (idx == 4'(c));

        // Channel storage and key-edge pulses.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q  <= '0;
                hi_q  <= '0;
                ins_q <= '0;
                rs_q  <= 1'b0;
                rl_q  <= 1'b0;
            end else begin
                rs_q <= hit_hi &&  wr_data[4] && !hi_q[4];
                rl_q <= hit_hi && !wr_data[4] &&  hi_q[4];
                if (hit_lo)  lo_q  <= wr_data;
                if (hit_hi)  hi_q  <= wr_data[5:0];
                if (hit_ins) ins_q <= wr_data;
            end
        end

        assign fnum[c]        = {hi_q[0], lo_q};
        assign block[c]       = hi_q[3:1];
        assign key[c]         = hi_q[4];
        assign sustain[c]     = hi_q[5];
        assign restart[c]     = rs_q;
        assign release_car[c] = rl_q;
        assign inst[c]        = ins_q[7:4];
        assign car_tl[c]      = {ins_q[3:0], 2'b00};
    end
endmodule

// File: rtl/fm_patch_decode.sv
// Splits one eight-byte instrument into modulator and carrier parameters and
// the feedback setting. Purely combinational; carrier level is supplied.
module fm_patch_decode
    import fm_reg_pkg::*;
(
    input  patch_t     patch,
    input  logic [5:0] car_tl,
    output op_param_t  mod_p,
    output op_param_t  car_p,
    output logic [2:0] fb_shift,
    output logic       fb_en
);
    logic [PATCH_BYTES-1:0][BYTE_W-1:0] b;
    logic [2:0]                         fb;

    assign b = patch;

    // Modulator fields.
    always_comb begin
        mod_p      = '0;
        {mod_p.am, mod_p.pm, mod_p.eg, mod_p.kr, mod_p.mult} = b[0];
        {mod_p.ksl, mod_p.tl} = b[2];
        mod_p.wf   = b[3][3];
        {mod_p.ar, mod_p.dr} = b[4];
        {mod_p.sl, mod_p.rr} = b[6];
    end

    // Carrier fields; level comes from the channel volume.
    always_comb begin
        car_p      = '0;
        {car_p.am, car_p.pm, car_p.eg, car_p.kr, car_p.mult} = b[1];
        car_p.ksl  = b[3][7:6];
        car_p.tl   = car_tl;
        car_p.wf   = b[3][4];
        {car_p.ar, car_p.dr} = b[5];
        {car_p.sl, car_p.rr} = b[7];
    end

    // Feedback code to shift, zero disables.
    assign fb       = b[3][2:0];
    assign fb_en    = (fb != 3'd0);
    assign fb_shift = fb_en ? (3'd7 - fb) : 3'd0;
endmodule

// File: rtl/fm_key_ctrl.sv
// Top: register write decoder and key control for a six-channel FM synth.
// Assumes preset_rom is constant; outputs follow a write by one cycle.
module fm_key_ctrl
    import fm_reg_pkg::*;
#(
    parameter int N_CH = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [5:0]                      wr_addr,
    input  logic [7:0]                      wr_data,
    input  logic [15*64-1:0]                preset_rom,
    output logic [N_CH*9-1:0]               ch_fnum,
    output logic [N_CH*3-1:0]               ch_block,
    output logic [N_CH-1:0]                 ch_sustain,
    output logic [N_CH-1:0]                 ch_key,
    output logic [N_CH-1:0]                 key_restart,
    output logic [N_CH-1:0]                 car_release,
    output logic [N_CH*3-1:0]               ch_fb_shift,
    output logic [N_CH-1:0]                 ch_fb_en,
    output logic [N_CH*2*33-1:0]            op_params
);
    localparam int N_OP = 2 * N_CH;

    patch_t                          custom;
    patch_t                          src_tab [N_PRESET+1];
    logic [N_CH-1:0][8:0]            fnum_w;
    logic [N_CH-1:0][2:0]            block_w;
    logic [N_CH-1:0][INST_W-1:0]     inst_w;
    logic [N_CH-1:0][5:0]            car_tl_w;
    logic [N_CH-1:0][2:0]            fbs_w;
    op_param_t [N_OP-1:0]            op_w;

    fm_custom_regs u_custom (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .custom  (custom)
    );

    fm_chan_regs #(.N_CH(N_CH)) u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .fnum        (fnum_w),
        .block       (block_w),
        .sustain     (ch_sustain),
        .key         (ch_key),
        .restart     (key_restart),
        .release_car (car_release),
        .inst        (inst_w),
        .car_tl      (car_tl_w)
    );

    // Instrument source table: entry 0 is the user instrument.
    assign src_tab[0] = custom;
    for (genvar p = 1; p <= N_PRESET; p++) begin : g_rom
        assign src_tab[p] = preset_rom[(p-1)*PATCH_W +: PATCH_W];
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_dec
        fm_patch_decode u_dec (
            .patch    (src_tab[inst_w[c]]),
            .car_tl   (car_tl_w[c]),
            .mod_p    (op_w[2*c]),
            .car_p    (op_w[2*c+1]),
            .fb_shift (fbs_w[c]),
            .fb_en    (ch_fb_en[c])
        );
    end

    assign ch_fnum     = fnum_w;
    assign ch_block    = block_w;
    assign ch_fb_shift = fbs_w;
    assign op_params   = op_w;
endmodule

// File: rtl/fm_key_ctrl_chk.sv
// Property checker for fm_key_ctrl; attached by bind below.
module fm_key_ctrl_chk
    import fm_reg_pkg::*;
#(
    parameter int N_CH = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [5:0]             wr_addr,
    input logic [N_CH*9-1:0]      ch_fnum,
    input logic [N_CH*3-1:0]      ch_block,
    input logic [N_CH-1:0]        ch_key,
    input logic [N_CH-1:0]        key_restart,
    input logic [N_CH-1:0]        car_release,
    input logic [N_CH*2*33-1:0]   op_params
);
    function automatic logic undefined_addr(input logic [5:0] a);
        if (a[5:4] == 2'd0) return a[3];
        return (a[3:0] >= 4'(N_CH));
    endfunction

    function automatic logic car_tl_aligned(input logic [N_CH*2*33-1:0] v);
        logic ok = 1'b1;
        for (int c = 0; c < N_CH; c++)
            if (v[(2*c+1)*OP_W + 17 +: 2] != 2'b00) ok = 1'b0;
        return ok;
    endfunction

    // R5: a restart only follows a write.
    p_restart_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_restart != '0) |-> $past(wr_en));

    // R5: a restarted channel shows its key flag set.
    p_restart_keyed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_restart & ~ch_key) == '0);

    // R6: a released channel shows its key flag clear.
    p_release_unkeyed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (car_release & ch_key) == '0);

    // R5: restart pulses never last two cycles.
    p_restart_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_restart != '0) |=> ((key_restart & $past(key_restart)) == '0));

    // R9: undefined writes leave state untouched.
    p_ignore_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && undefined_addr(wr_addr)) |=>
        ($stable(ch_fnum) && $stable(ch_block) && $stable(ch_key) && $stable(op_params)));

    // R4: carrier level is a multiple of four.
    p_car_tl_scaled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        car_tl_aligned(op_params));
endmodule

bind fm_key_ctrl fm_key_ctrl_chk #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .ch_fnum     (ch_fnum),
    .ch_block    (ch_block),
    .ch_key      (ch_key),
    .key_restart (key_restart),
    .car_release (car_release),
    .op_params   (op_params)
);

// File: tb/fm_key_ctrl_tb.sv
module fm_key_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 6;
    localparam int OPW = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [15*64-1:0] preset_rom;
    logic [NC*9-1:0] ch_fnum;
    logic [NC*3-1:0] ch_block;
    logic [NC-1:0] ch_sustain, ch_key, key_restart, car_release, ch_fb_en;
    logic [NC*3-1:0] ch_fb_shift;
    logic [NC*2*OPW-1:0] op_params;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 0;
    bit done = 0;
    string cur_req = "R10";

    // Reference model state
    int m_cust [8];
    int m_lo [NC];
    int m_hi [NC];
    int m_iv [NC];
    bit m_rs [NC];
    bit m_rl [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    fm_key_ctrl #(.N_CH(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .preset_rom(preset_rom), .ch_fnum(ch_fnum), .ch_block(ch_block),
        .ch_sustain(ch_sustain), .ch_key(ch_key), .key_restart(key_restart),
        .car_release(car_release), .ch_fb_shift(ch_fb_shift), .ch_fb_en(ch_fb_en),
        .op_params(op_params)
    );

    function automatic int prom_byte(int p, int k);
        return (p * 53 + k * 29 + 7) & 255;
    endfunction

    initial begin
        for (int p = 1; p <= 15; p++)
            for (int k = 0; k < 8; k++)
                preset_rom[((p-1)*8+k)*8 +: 8] = 8'(prom_byte(p, k));
    end

    // Model update on each clock edge
    always @(posedge clk) begin
        for (int c = 0; c < NC; c++) begin m_rs[c] = 0; m_rl[c] = 0; end
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) m_cust[k] = 0;
            for (int c = 0; c < NC; c++) begin m_lo[c] = 0; m_hi[c] = 0; m_iv[c] = 0; end
        end else if (wr_en) begin
            int a, d;
            a = int'(wr_addr);
            d = int'(wr_data);
            if (a < 8) m_cust[a] = d;
            else if (a >= 16 && a < 16 + NC) m_lo[a-16] = d;
            else if (a >= 32 && a < 32 + NC) begin
                bit was, now;
                was = ((m_hi[a-32] >> 4) & 1) != 0;
                now = ((d >> 4) & 1) != 0;
                m_rs[a-32] = now && !was;
                m_rl[a-32] = !now && was;
                m_hi[a-32] = d;
            end
            else if (a >= 48 && a < 48 + NC) m_iv[a-48] = d;
        end
    end

    function automatic int src_byte(int c, int k);
        int p;
        p = m_iv[c] >> 4;
        return (p == 0) ? m_cust[k] : prom_byte(p, k);
    endfunction

    task automatic chk(string what, logic [511:0] act, logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            logic [NC*9-1:0] e_fn;
            logic [NC*3-1:0] e_bl, e_fs;
            logic [NC-1:0] e_su, e_ky, e_rs, e_rl, e_fe;
            logic [NC*2*OPW-1:0] e_op;
            for (int c = 0; c < NC; c++) begin
                longint mv, cv;
                int b3, fb;
                e_fn[c*9 +: 9] = 9'(((m_hi[c] & 1) << 8) | m_lo[c]);
                e_bl[c*3 +: 3] = 3'((m_hi[c] >> 1) & 7);
                e_su[c] = ((m_hi[c] >> 5) & 1) != 0;
                e_ky[c] = ((m_hi[c] >> 4) & 1) != 0;
                e_rs[c] = m_rs[c];
                e_rl[c] = m_rl[c];
                b3 = src_byte(c, 3);
                fb = b3 & 7;
                e_fe[c] = (fb != 0);
                e_fs[c*3 +: 3] = (fb != 0) ? 3'(7 - fb) : 3'd0;
                mv = (longint'(src_byte(c, 0)) << 25) | (longint'(src_byte(c, 2)) << 17)
                   | (longint'((b3 >> 3) & 1) << 16) | (longint'(src_byte(c, 4)) << 8)
                   | longint'(src_byte(c, 6));
                cv = (longint'(src_byte(c, 1)) << 25) | (longint'((b3 >> 6) & 3) << 23)
                   | (longint'((m_iv[c] & 15) * 4) << 17) | (longint'((b3 >> 4) & 1) << 16)
                   | (longint'(src_byte(c, 5)) << 8) | longint'(src_byte(c, 7));
                e_op[(2*c)*OPW +: OPW]   = mv[32:0];
                e_op[(2*c+1)*OPW +: OPW] = cv[32:0];
            end
            chk("fnum", 512'(ch_fnum), 512'(e_fn));
            chk("block", 512'(ch_block), 512'(e_bl));
            chk("sustain", 512'(ch_sustain), 512'(e_su));
            chk("key", 512'(ch_key), 512'(e_ky));
            chk("restart", 512'(key_restart), 512'(e_rs));
            chk("release", 512'(car_release), 512'(e_rl));
            chk("fb_shift", 512'(ch_fb_shift), 512'(e_fs));
            chk("fb_en", 512'(ch_fb_en), 512'(e_fe));
            chk("op_params", 512'(op_params), 512'(e_op));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Back-to-back writes with no idle cycle between
    task automatic wr2(input logic [5:0] a0, input logic [7:0] d0,
                       input logic [5:0] a1, input logic [7:0] d1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a0; wr_data = d0;
        @(negedge clk);
        wr_addr = a1; wr_data = d1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R10: reset state
        @(posedge clk);
        @(negedge clk);
        cmp_en = 1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: frequency, block and sustain fields
        cur_req = "R3";
        for (int c = 0; c < NC; c++) begin
            wr(6'(16 + c), 8'(37 * c + 11));
            wr(6'(32 + c), 8'((c & 1) | ((c % 8) << 1) | ((c & 2) << 4)));
        end

        // R5: key-on edge, repeat key-on, R6: key-off edge, repeat key-off
        cur_req = "R5";
        wr(6'h22, 8'h10);
        wr(6'h22, 8'h1F);
        cur_req = "R6";
        wr(6'h22, 8'h0E);
        wr(6'h22, 8'h00);
        // Same-cycle: key-on with new block/frequency, then back-to-back channels
        cur_req = "R5";
        wr2(6'h20, 8'h3B, 6'h21, 8'h17);
        cur_req = "R6";
        wr2(6'h20, 8'h00, 6'h25, 8'h10);
        wr2(6'h25, 8'h20, 6'h21, 8'h00);

        // R1: user instrument bytes on channels with instrument 0
        cur_req = "R1";
        for (int k = 0; k < 8; k++) wr(6'(k), 8'(8'hA5 ^ (k * 8'h1D)));
        wr(6'h24, 8'h10);
        wr(6'h03, 8'h5C);

        // R2: preset selection, then user writes must not touch it
        cur_req = "R2";
        wr(6'h31, 8'h5A);
        wr(6'h35, 8'hF3);
        wr(6'h02, 8'h3C);
        wr(6'h06, 8'hE1);

        // R4: volume scaling and modulator level from byte 2
        cur_req = "R4";
        wr(6'h30, 8'h0F);
        wr(6'h32, 8'h01);
        wr(6'h02, 8'hFF);

        // R7: every byte decode with distinct patterns
        cur_req = "R7";
        for (int k = 0; k < 8; k++) wr(6'(k), 8'(8'h5A + k * 8'h33));
        wr(6'h34, 8'hA7);

        // R8: feedback codes 0, 1, 7
        cur_req = "R8";
        wr(6'h03, 8'h00);
        wr(6'h03, 8'h01);
        wr(6'h03, 8'hF7);

        // R9: undefined addresses
        cur_req = "R9";
        wr(6'h08, 8'hFF);
        wr(6'h0F, 8'h77);
        wr(6'h16, 8'h99);
        wr(6'h1F, 8'h55);
        wr(6'h26, 8'h10);
        wr(6'h2F, 8'h3F);
        wr(6'h3A, 8'hF0);
        wr(6'h3F, 8'h12);

        // Mixed random traffic
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            logic [5:0] a;
            a = 6'($urandom_range(0, 63));
            if ((i & 1) == 0) a = 6'(32 + $urandom_range(0, NC - 1));
            wr(a, 8'($urandom_range(0, 255)));
        end

        // R10: reset again after activity
        cur_req = "R10";
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule